// File: doc/BRIEF.md
# Escaping Frame Encoder

The block sits between a byte producer and a serial transmitter. Each beat it takes carries one byte together with start-of-frame and end-of-frame flags. When framing is on, it puts a separator byte on the wire before the first payload byte and after the last one. Inside the payload, four byte values are reserved: the configured separator, the escape byte 0xDB, and the flow-control bytes 0x11 and 0x13. Each has its own enable. When its enable is set, the byte is sent as a configurable two-byte pair instead of as itself.

Both sides use a valid/ready handshake. A single input beat can expand into as many as four output bytes: an opening separator, an escaped pair, and a closing separator. The encoder holds the extra bytes in a small pending store and keeps input ready low until that store is empty, so no input byte is lost under backpressure. A one-cycle pulse follows every separator the transmitter accepts. A beat marked as carrying no data byte lets a frame with an empty payload be sent.

Top module: `esc_frame_enc`

## Requirements
- R1: After reset, out_valid and sep_pulse are low and in_ready is high.
- R2: With cfg_sep_en high, a beat with in_sof is preceded on the output by cfg_sep_char, and a beat with in_eof is followed by cfg_sep_char.
- R3: With cfg_sep_en low, no separator is inserted; payload bytes, escaped where enabled, are the only output.
- R4: With cfg_esc_en[0] set, a payload byte equal to cfg_sep_char is sent as cfg_sep_pair[15:8] followed by cfg_sep_pair[7:0] (defaults 0xC0, then 0xDB 0xDC).
- R5: With cfg_esc_en[1] set, a payload byte 0xDB is sent as cfg_esc_pair[15:8] then cfg_esc_pair[7:0] (default 0xDB 0xDD).
- R6: With cfg_esc_en[2] set, payload 0x11 is sent as cfg_xon_pair[15:8] then [7:0] (default 0xDB 0xDE). With cfg_esc_en[3] set, payload 0x13 is sent as cfg_xoff_pair[15:8] then [7:0] (default 0xDB 0xDF).
- R7: A reserved byte whose enable bit is clear is sent unchanged as a single byte.
- R8: When a byte matches more than one enabled reserved value, the lowest enable index wins (separator first, then 0xDB, 0x11, 0x13).
- R9: While out_valid is high and out_ready low, out_data stays stable and in_ready is low. Input ready also stays low while bytes from an earlier beat are still pending. No byte is lost or reordered.
- R10: sep_pulse is high for exactly the one cycle after each framing separator is accepted (out_valid and out_ready high), and low otherwise.
- R11: A beat with in_void, in_sof and in_eof high and cfg_sep_en high produces exactly two separators and no payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Encoder can accept a beat |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Beat opens a frame |
| in_eof | input | 1 | Beat closes a frame |
| in_void | input | 1 | Beat carries no payload byte (flags only) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Transmitter accepts the byte |
| out_data | output | 8 | Encoded byte |
| sep_pulse | output | 1 | One-cycle pulse after a separator is accepted |
| cfg_sep_en | input | 1 | Enable separator framing |
| cfg_sep_char | input | 8 | Separator value |
| cfg_esc_en | input | 4 | Escape enables: [0] separator, [1] 0xDB, [2] 0x11, [3] 0x13 |
| cfg_sep_pair | input | 16 | Replacement for separator, first byte in [15:8] |
| cfg_esc_pair | input | 16 | Replacement for 0xDB, first byte in [15:8] |
| cfg_xon_pair | input | 16 | Replacement for 0x11, first byte in [15:8] |
| cfg_xoff_pair | input | 16 | Replacement for 0x13, first byte in [15:8] |

## Verification
The hardest case to reach is a one-byte frame whose payload needs escaping while the transmitter stalls. One accepted beat then leaves three bytes pending behind the output register, and input ready has to stay low across every stalled cycle. The stimulus reaches this case by sending single-beat frames of reserved bytes while a pseudo-random pattern holds out_ready low about three cycles in four. The scoreboard then checks that every byte arrives in order. The priority between overlapping matches is reached by setting the separator to 0x11, so that two enables claim the same byte.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned NUM_RSV = 4;
  localparam int unsigned MAX_SEQ = 4;

  localparam logic [CHAR_W-1:0] ESC_CHAR  = 8'hDB;
  localparam logic [CHAR_W-1:0] XON_CHAR  = 8'h11;
  localparam logic [CHAR_W-1:0] XOFF_CHAR = 8'h13;

  localparam logic [CHAR_W-1:0]   DFLT_SEP_CHAR = 8'hC0;
  localparam logic [2*CHAR_W-1:0] DFLT_SEP_PAIR  = 16'hDBDC;
  localparam logic [2*CHAR_W-1:0] DFLT_ESC_PAIR  = 16'hDBDD;
  localparam logic [2*CHAR_W-1:0] DFLT_XON_PAIR  = 16'hDBDE;
  localparam logic [2*CHAR_W-1:0] DFLT_XOFF_PAIR = 16'hDBDF;

  typedef enum logic [1:0] {
    RSV_SEP  = 2'd0,
    RSV_ESC  = 2'd1,
    RSV_XON  = 2'd2,
    RSV_XOFF = 2'd3
  } rsv_idx_e;
endpackage

// File: rtl/esc_enc_rst_sync.sv
module esc_enc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/esc_enc_classify.sv
module esc_enc_classify #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_RSV = 4
) (
  input  logic [DATA_W-1:0]   byte_i,
  input  logic [DATA_W-1:0]   char_i [NUM_RSV],
  input  logic [2*DATA_W-1:0] pair_i [NUM_RSV],
  input  logic [NUM_RSV-1:0]  en_i,
  output logic                hit_o,
  output logic [2*DATA_W-1:0] pair_o
);
  logic [NUM_RSV-1:0] match;

  for (genvar g = 0; g < NUM_RSV; g++) begin : g_match
    assign match[g] = en_i[g] && (byte_i == char_i[g]);
  end

  // Lowest index has priority: scan from the top so it is written last.
  always_comb begin
    hit_o  = 1'b0;
    pair_o = '0;
    for (int i = NUM_RSV - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        pair_o = pair_i[i];
      end
    end
  end
endmodule

// File: rtl/esc_enc_seq.sv
module esc_enc_seq #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MAX_SEQ = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic                in_sof_i,
  input  logic                in_eof_i,
  input  logic                in_void_i,
  input  logic                hit_i,
  input  logic [2*DATA_W-1:0] pair_i,
  input  logic                sep_en_i,
  input  logic [DATA_W-1:0]   sep_char_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [DATA_W-1:0]   out_data_o,
  output logic                sep_pulse_o
);
  localparam int unsigned PEND  = MAX_SEQ - 1;
  localparam int unsigned CNT_W = $clog2(MAX_SEQ + 1);
  localparam int unsigned IDX_W = $clog2(MAX_SEQ);

  // Expansion of the offered beat
  logic [DATA_W-1:0] bld_data [MAX_SEQ];
  logic [MAX_SEQ-1:0] bld_sep;
  logic [CNT_W-1:0]   bld_len;

  // State
  logic              out_valid_q, out_valid_d;
  logic [DATA_W-1:0] out_data_q,  out_data_d;
  logic              out_sep_q,   out_sep_d;
  logic [DATA_W-1:0] pend_data_q [PEND];
  logic [DATA_W-1:0] pend_data_d [PEND];
  logic [PEND-1:0]   pend_sep_q,  pend_sep_d;
  logic [CNT_W-1:0]  pend_cnt_q,  pend_cnt_d;
  logic              sep_pulse_q, sep_pulse_d;

  logic out_free, fire, take, upd_en;

  always_comb begin
    for (int i = 0; i < MAX_SEQ; i++) bld_data[i] = '0;
    bld_sep = '0;
    bld_len = '0;
    if (sep_en_i && in_sof_i) begin
      bld_data[bld_len[IDX_W-1:0]] = sep_char_i;
      bld_sep[bld_len[IDX_W-1:0]]  = 1'b1;
      bld_len = bld_len + CNT_W'(1);
    end
    if (!in_void_i) begin
      if (hit_i) begin
        bld_data[bld_len[IDX_W-1:0]] = pair_i[2*DATA_W-1:DATA_W];
        bld_len = bld_len + CNT_W'(1);
        bld_data[bld_len[IDX_W-1:0]] = pair_i[DATA_W-1:0];
        bld_len = bld_len + CNT_W'(1);
      end else begin
        bld_data[bld_len[IDX_W-1:0]] = in_data_i;
        bld_len = bld_len + CNT_W'(1);
      end
    end
    if (sep_en_i && in_eof_i) begin
      bld_data[bld_len[IDX_W-1:0]] = sep_char_i;
      bld_sep[bld_len[IDX_W-1:0]]  = 1'b1;
      bld_len = bld_len + CNT_W'(1);
    end
  end

  assign out_free   = !out_valid_q || out_ready_i;
  assign fire       = out_valid_q && out_ready_i;
  assign in_ready_o = out_free && (pend_cnt_q == '0);
  assign take       = in_valid_i && in_ready_o;
  assign upd_en     = take || fire;

  // Next state
  always_comb begin
    out_valid_d = out_valid_q;
    out_data_d  = out_data_q;
    out_sep_d   = out_sep_q;
    pend_data_d = pend_data_q;
    pend_sep_d  = pend_sep_q;
    pend_cnt_d  = pend_cnt_q;
    if (take) begin
      out_valid_d = (bld_len != '0);
      out_data_d  = bld_data[0];
      out_sep_d   = bld_sep[0];
      pend_cnt_d  = (bld_len == '0) ? '0 : bld_len - CNT_W'(1);
      for (int i = 0; i < PEND; i++) begin
        pend_data_d[i] = bld_data[i+1];
        pend_sep_d[i]  = bld_sep[i+1];
      end
    end else if (fire) begin
      if (pend_cnt_q != '0) begin
        out_data_d = pend_data_q[0];
        out_sep_d  = pend_sep_q[0];
        for (int i = 0; i < PEND - 1; i++) begin
          pend_data_d[i] = pend_data_q[i+1];
          pend_sep_d[i]  = pend_sep_q[i+1];
        end
        pend_data_d[PEND-1] = '0;
        pend_sep_d[PEND-1]  = 1'b0;
        pend_cnt_d = pend_cnt_q - CNT_W'(1);
      end else begin
        out_valid_d = 1'b0;
      end
    end
    sep_pulse_d = fire && out_sep_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_sep_q   <= 1'b0;
      for (int i = 0; i < PEND; i++) pend_data_q[i] <= '0;
      pend_sep_q  <= '0;
      pend_cnt_q  <= '0;
      sep_pulse_q <= 1'b0;
    end else begin
      if (upd_en) begin
        out_valid_q <= out_valid_d;
        out_data_q  <= out_data_d;
        out_sep_q   <= out_sep_d;
        for (int i = 0; i < PEND; i++) pend_data_q[i] <= pend_data_d[i];
        pend_sep_q  <= pend_sep_d;
        pend_cnt_q  <= pend_cnt_d;
      end
      sep_pulse_q <= sep_pulse_d;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign sep_pulse_o = sep_pulse_q;
endmodule

// File: rtl/esc_frame_enc.sv
module esc_frame_enc
  import esc_enc_pkg::*;
#(
  parameter int unsigned DATA_W = CHAR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic                in_void,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                sep_pulse,
  input  logic                cfg_sep_en,
  input  logic [DATA_W-1:0]   cfg_sep_char,
  input  logic [NUM_RSV-1:0]  cfg_esc_en,
  input  logic [2*DATA_W-1:0] cfg_sep_pair,
  input  logic [2*DATA_W-1:0] cfg_esc_pair,
  input  logic [2*DATA_W-1:0] cfg_xon_pair,
  input  logic [2*DATA_W-1:0] cfg_xoff_pair
);
  localparam int unsigned PAIR_W = 2 * DATA_W;

  logic              rst_sync_n;
  logic [DATA_W-1:0] rsv_char [NUM_RSV];
  logic [PAIR_W-1:0] rsv_pair [NUM_RSV];
  logic              hit;
  logic [PAIR_W-1:0] pair;

  assign rsv_char[RSV_SEP]  = cfg_sep_char;
  assign rsv_char[RSV_ESC]  = DATA_W'(ESC_CHAR);
  assign rsv_char[RSV_XON]  = DATA_W'(XON_CHAR);
  assign rsv_char[RSV_XOFF] = DATA_W'(XOFF_CHAR);
  assign rsv_pair[RSV_SEP]  = cfg_sep_pair;
  assign rsv_pair[RSV_ESC]  = cfg_esc_pair;
  assign rsv_pair[RSV_XON]  = cfg_xon_pair;
  assign rsv_pair[RSV_XOFF] = cfg_xoff_pair;

  esc_enc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  esc_enc_classify #(.DATA_W(DATA_W), .NUM_RSV(NUM_RSV)) i_classify (
    .byte_i (in_data),
    .char_i (rsv_char),
    .pair_i (rsv_pair),
    .en_i   (cfg_esc_en),
    .hit_o  (hit),
    .pair_o (pair)
  );

  esc_enc_seq #(.DATA_W(DATA_W), .MAX_SEQ(MAX_SEQ)) i_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .in_sof_i    (in_sof),
    .in_eof_i    (in_eof),
    .in_void_i   (in_void),
    .hit_i       (hit),
    .pair_i      (pair),
    .sep_en_i    (cfg_sep_en),
    .sep_char_i  (cfg_sep_char),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .sep_pulse_o (sep_pulse)
  );
endmodule

// File: rtl/esc_frame_enc_chk.sv
module esc_frame_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_void,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       sep_pulse,
  input logic [7:0] cfg_sep_char,
  input logic [3:0] cfg_esc_en
);
  // R9: a stalled output byte is held
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: no input is taken while the output is stalled
  a_r9_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5: an escaped 0xDB leaves a second byte pending, so input waits
  a_r5_second_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_void && cfg_esc_en[1] && in_data == 8'hDB)
      |=> !in_ready);

  // R10: a pulse only follows an accepted separator value
  a_r10_pulse_after_sep: assert property (@(posedge clk) disable iff (!rst_n)
    sep_pulse |-> $past(out_valid && out_ready && out_data == cfg_sep_char));
endmodule

bind esc_frame_enc esc_frame_enc_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .in_void      (in_void),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .sep_pulse    (sep_pulse),
  .cfg_sep_char (cfg_sep_char),
  .cfg_esc_en   (cfg_esc_en)
);

// File: tb/test_esc_frame_enc.sv
module test_esc_frame_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        in_void = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        sep_pulse;
  logic        cfg_sep_en = 1'b1;
  logic [7:0]  cfg_sep_char = 8'hC0;
  logic [3:0]  cfg_esc_en = 4'hF;
  logic [15:0] cfg_sep_pair = 16'hDBDC;
  logic [15:0] cfg_esc_pair = 16'hDBDD;
  logic [15:0] cfg_xon_pair = 16'hDBDE;
  logic [15:0] cfg_xoff_pair = 16'hDBDF;

  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_fire_sep = 1'b0;

  logic [7:0] q_data[$];
  bit         q_sep[$];
  string      q_req[$];

  always #4 clk = ~clk;

  esc_frame_enc i_esc_frame_enc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_void(in_void),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sep_pulse(sep_pulse),
    .cfg_sep_en(cfg_sep_en), .cfg_sep_char(cfg_sep_char), .cfg_esc_en(cfg_esc_en),
    .cfg_sep_pair(cfg_sep_pair), .cfg_esc_pair(cfg_esc_pair),
    .cfg_xon_pair(cfg_xon_pair), .cfg_xoff_pair(cfg_xoff_pair)
  );

  task automatic push_exp(input logic [7:0] b, input bit s, input string r);
    q_data.push_back(b);
    q_sep.push_back(s);
    q_req.push_back(r);
  endtask

  // Driver: expected bytes from the requirements, then the handshake
  task automatic send(input logic [7:0] d, input bit sof, input bit eof,
                      input bit vd, input string r);
    logic [7:0]  chars [4];
    logic [15:0] pairs [4];
    bit          found;
    logic [15:0] pr;
    chars = '{cfg_sep_char, 8'hDB, 8'h11, 8'h13};
    pairs = '{cfg_sep_pair, cfg_esc_pair, cfg_xon_pair, cfg_xoff_pair};
    found = 1'b0;
    pr = '0;
    if (cfg_sep_en && sof) push_exp(cfg_sep_char, 1'b1, r);
    if (!vd) begin
      for (int i = 0; i < 4; i++) begin
        if (!found && cfg_esc_en[i] && d == chars[i]) begin
          found = 1'b1;
          pr = pairs[i];
        end
      end
      if (found) begin
        push_exp(pr[15:8], 1'b0, r);
        push_exp(pr[7:0], 1'b0, r);
      end else begin
        push_exp(d, 1'b0, r);
      end
    end
    if (cfg_sep_en && eof) push_exp(cfg_sep_char, 1'b1, r);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
    in_eof   = eof;
    in_void  = vd;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] bytes [], input string r);
    for (int i = 0; i < bytes.size(); i++)
      send(bytes[i], i == 0, i == bytes.size() - 1, 1'b0, r);
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: sets out_ready, compares each transferred byte and the pulse
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_fire_sep || sep_pulse) begin
        checks++;
        if (sep_pulse !== prev_fire_sep) begin
          fails++;
          $display("FAIL R10 sep_pulse actual=%0b expected=%0b", sep_pulse, prev_fire_sep);
        end
      end
      case (stall_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0];
        default: out_ready = (lfsr[1:0] == 2'b00);
      endcase
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      prev_fire_sep = 1'b0;
      if (out_valid && out_ready) begin
        checks++;
        if (q_data.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected byte actual=%02h expected=none", out_data);
        end else begin
          logic [7:0] eb;
          bit es;
          string er;
          eb = q_data.pop_front();
          es = q_sep.pop_front();
          er = q_req.pop_front();
          prev_fire_sep = es;
          if (out_data !== eb) begin
            fails++;
            $display("FAIL %s out_data actual=%02h expected=%02h", er, out_data, eb);
          end
        end
      end
    end
  end

  initial begin
    fork
      begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        checks++; if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 out_valid actual=%0b expected=0", out_valid); end
        checks++; if (sep_pulse !== 1'b0) begin fails++; $display("FAIL R1 sep_pulse actual=%0b expected=0", sep_pulse); end
        checks++; if (in_ready !== 1'b1) begin fails++; $display("FAIL R1 in_ready actual=%0b expected=1", in_ready); end
        mon_on = 1'b1;

        // R2 plain frame with framing
        send_frame('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, "R2");
        drain();

        // R4, R5, R6 escaping with random stalls
        stall_mode = 1;
        send(8'hC0, 1'b1, 1'b0, 1'b0, "R4");
        send(8'hDB, 1'b0, 1'b0, 1'b0, "R5");
        send(8'h11, 1'b0, 1'b0, 1'b0, "R6");
        send(8'h13, 1'b0, 1'b1, 1'b0, "R6");
        drain();

        // R7 enables clear
        stall_mode = 0;
        cfg_esc_en = 4'h0;
        send_frame('{8'hC0, 8'hDB, 8'h11, 8'h13}, "R7");
        drain();
        cfg_esc_en = 4'b0101;
        send_frame('{8'hDB, 8'h11, 8'h13, 8'hC0}, "R7");
        drain();

        // R3 framing off
        cfg_esc_en = 4'hF;
        cfg_sep_en = 1'b0;
        send_frame('{8'h20, 8'hC0, 8'h21}, "R3");
        drain();
        cfg_sep_en = 1'b1;

        // R11 empty payload frame
        send(8'h55, 1'b1, 1'b1, 1'b1, "R11");
        send(8'h66, 1'b1, 1'b1, 1'b1, "R11");
        drain();

        // R8 overlapping matches, custom pairs
        cfg_sep_char = 8'h11;
        cfg_sep_pair = 16'hAA55;
        cfg_xon_pair = 16'h7E01;
        cfg_xoff_pair = 16'h7E02;
        send_frame('{8'h11, 8'h13, 8'hC0}, "R8");
        drain();
        cfg_esc_en = 4'b0100;
        send_frame('{8'h11, 8'h13}, "R8");
        drain();
        cfg_esc_en = 4'hF;
        cfg_sep_char = 8'hC0;
        cfg_sep_pair = 16'hDBDC;
        cfg_xon_pair = 16'hDBDE;
        cfg_xoff_pair = 16'hDBDF;

        // R9 heavy backpressure: single-beat frames of reserved bytes
        stall_mode = 2;
        for (int k = 0; k < 24; k++) begin
          logic [7:0] v;
          case (k % 6)
            0: v = 8'hC0;
            1: v = 8'hDB;
            2: v = 8'h11;
            3: v = 8'h13;
            4: v = 8'h5A;
            default: v = 8'(k);
          endcase
          send(v, (k % 3) == 0, (k % 3) != 1, 1'b0, "R9");
        end
        drain();
        stall_mode = 0;
        drain();

        checks++;
        if (q_data.size() != 0) begin
          fails++;
          $display("FAIL R9 leftover actual=%0d expected=0", q_data.size());
        end
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule